// File: doc/BRIEF.md
# Response Age Tracker and Lateness Classifier

This block sits at the network interface of a memory controller. Each request that arrives from the mesh carries a 12-bit age, which is the delay it has built up so far, and the identity of the core that sent it. The block stores that age and the source core in a pending-slot table indexed by the transaction tag, and it timestamps the entry with a free-running local cycle counter. No global time base is involved.

When the controller injects the matching response, the block works out how many local cycles the request spent queued and in service. It scales that count by a per-node frequency multiplier so that nodes at different clock rates add comparable amounts. It adds the scaled count to the stored age, saturating rather than wrapping, and writes the new age into the response header flit. It then compares the age with the lateness threshold for the requesting core. A response whose age is above its core's threshold gets the high-priority bit set, so that routers expedite it.

The cores keep their own thresholds up to date by sending update messages. Each update overwrites one entry of a 32-entry threshold table. Requests are never classified; only responses are.

Top module: `age_lateness_unit`

## Requirements
- R1: `rsp_valid_o` is high exactly in the cycle after a cycle with `rsp_valid_i` high. Threshold updates and requests on their own never produce an output.
- R2: On `req_valid_i`, the block stores `req_age_i` and `req_core_i` in the slot selected by `req_tag_i`. The slot stays pending until a response names the same tag.
- R3: Let k be the number of rising clock edges from the request edge to the response edge, and let `freq_mult_i` be read as unsigned with 4 fractional bits (16 means 1.0). The output age in `rsp_hdr_o[11:0]` is then the stored age plus floor(k * `freq_mult_i` / 16).
- R4: The output age saturates at 4095 and never wraps.
- R5: A threshold update writes `thr_upd_value_i` into the entry for `thr_upd_core_i`. A response processed in the same cycle as the update still uses the old value; responses in later cycles use the new one.
- R6: Bit 17 of `rsp_hdr_o` (high priority) is 1 when the output age is strictly greater than the requesting core's threshold. An age equal to the threshold gives 0.
- R7: `rsp_hdr_o[127:18]` equals `rsp_hdr_i[127:18]` from the response cycle, and `rsp_hdr_o[16:12]` carries the core stored with the request.
- R8: After reset, `rsp_valid_o` is low and every threshold entry is 4095, so no response is marked until its core sends an update.
- R9: An update to one core's threshold leaves the classification of every other core's responses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freq_mult_i | input | 8 | Node frequency multiplier, 4 fractional bits |
| thr_upd_valid_i | input | 1 | Threshold update strobe |
| thr_upd_core_i | input | 5 | Core whose threshold is written |
| thr_upd_value_i | input | 12 | New threshold |
| req_valid_i | input | 1 | Request arrival strobe |
| req_tag_i | input | 3 | Transaction slot of the request |
| req_core_i | input | 5 | Source core from the request header |
| req_age_i | input | 12 | Age from the request header |
| rsp_valid_i | input | 1 | Response injection strobe |
| rsp_tag_i | input | 3 | Transaction slot of the response |
| rsp_hdr_i | input | 128 | Response header flit from the controller |
| rsp_valid_o | output | 1 | Updated response header valid |
| rsp_hdr_o | output | 128 | Response header with age, core and priority fields written |

## Verification
The assertions rely on three properties of the inputs: a response names only a tag that is pending, a request and a response never name the same tag in the same cycle, and no request stays outstanding for 65536 cycles or more. The stimulus meets all three. It allocates request tags only from slots the bench knows are free, it draws response tags only from slots it knows are pending, and it keeps every transaction a few hundred cycles long at most. Within those bounds it varies the multiplier and sends threshold updates to random cores, including one update that lands in the same cycle as a response for the same core.

// File: rtl/age_pkg.sv
package age_pkg;
  localparam int HDR_W    = 128;
  localparam int AGE_W    = 12;
  localparam int CORE_W   = 5;
  localparam int CNT_W    = 16;
  // header field positions decoded by routers
  localparam int AGE_LSB  = 0;
  localparam int CORE_LSB = 12;
  localparam int PRIO_BIT = 17;

  typedef struct packed {
    logic              vld;
    logic [CORE_W-1:0] core;
    logic [AGE_W-1:0]  age;
    logic [CNT_W-1:0]  stamp;
  } slot_ent_t;
endpackage

// File: rtl/age_scaler.sv
module age_scaler #(
  parameter int AGE_W  = 12,
  parameter int CNT_W  = 16,
  parameter int MULT_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic [AGE_W-1:0]  age_i,
  input  logic [CNT_W-1:0]  elapsed_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic [AGE_W-1:0]  age_o
);
  localparam int PROD_W = CNT_W + MULT_W;
  localparam int INC_W  = PROD_W - FRAC_W;
  localparam logic [INC_W:0] SAT = {{(INC_W+1-AGE_W){1'b0}}, {AGE_W{1'b1}}};

  logic [PROD_W-1:0] prod;
  logic [INC_W-1:0]  inc;
  logic [INC_W:0]    sum;

  always_comb begin
    prod  = PROD_W'(elapsed_i) * PROD_W'(mult_i);
    inc   = prod[PROD_W-1:FRAC_W];  // floor of fractional product
    sum   = {1'b0, inc} + (INC_W+1)'(age_i);
    age_o = (sum > SAT) ? {AGE_W{1'b1}} : sum[AGE_W-1:0];
  end
endmodule

// File: rtl/age_thr_table.sv
module age_thr_table #(
  parameter int NUM_CORES = 32,
  parameter int IDX_W     = 5,
  parameter int AGE_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [AGE_W-1:0] wr_val_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [AGE_W-1:0] rd_val_o
);
  logic [AGE_W-1:0] thr_q [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  thr_q[g] <= {AGE_W{1'b1}};
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    thr_q[g] <= wr_val_i;
    end
  end

  // out-of-range cores read as never late
  assign rd_val_o = (int'(rd_idx_i) < NUM_CORES) ? thr_q[rd_idx_i] : {AGE_W{1'b1}};
endmodule

// File: rtl/age_slot_table.sv
module age_slot_table import age_pkg::*; #(
  parameter int NUM_SLOTS = 8,
  parameter int TAG_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [TAG_W-1:0] wr_idx_i,
  input  slot_ent_t        wr_ent_i,
  input  logic             clr_en_i,
  input  logic [TAG_W-1:0] clr_idx_i,
  input  logic [TAG_W-1:0] rd_idx_i,
  output slot_ent_t        rd_ent_o
);
  slot_ent_t ent_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == TAG_W'(g))     ent_q[g] <= wr_ent_i;
      else if (clr_en_i && clr_idx_i == TAG_W'(g))   ent_q[g].vld <= 1'b0;
    end
  end

  assign rd_ent_o = ent_q[rd_idx_i];
endmodule

// File: rtl/age_lateness_unit.sv
module age_lateness_unit import age_pkg::*; #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_CORES = 32,
  parameter int MULT_W    = 8,
  parameter int FRAC_W    = 4,
  localparam int TAG_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MULT_W-1:0] freq_mult_i,
  input  logic              thr_upd_valid_i,
  input  logic [CORE_W-1:0] thr_upd_core_i,
  input  logic [AGE_W-1:0]  thr_upd_value_i,
  input  logic              req_valid_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [AGE_W-1:0]  req_age_i,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [HDR_W-1:0]  rsp_hdr_i,
  output logic              rsp_valid_o,
  output logic [HDR_W-1:0]  rsp_hdr_o
);
  logic [CNT_W-1:0]  cnt_q;
  slot_ent_t         new_ent, pend;
  logic              pend_vld;
  logic [CORE_W-1:0] pend_core;
  logic [AGE_W-1:0]  pend_age;
  logic [CNT_W-1:0]  elapsed;
  logic [AGE_W-1:0]  age_new, thr_cur;
  logic              late;
  logic [HDR_W-1:0]  hdr_d, hdr_q;
  logic              vld_q;

  // local time base, differences taken modulo 2**CNT_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    new_ent.vld   = 1'b1;
    new_ent.core  = req_core_i;
    new_ent.age   = req_age_i;
    new_ent.stamp = cnt_q;
  end

  age_slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (req_valid_i),
    .wr_idx_i  (req_tag_i),
    .wr_ent_i  (new_ent),
    .clr_en_i  (rsp_valid_i),
    .clr_idx_i (rsp_tag_i),
    .rd_idx_i  (rsp_tag_i),
    .rd_ent_o  (pend)
  );

  assign pend_vld  = pend.vld;
  assign pend_core = pend.core;
  assign pend_age  = pend.age;
  assign elapsed   = cnt_q - pend.stamp;

  age_scaler #(.AGE_W(AGE_W), .CNT_W(CNT_W), .MULT_W(MULT_W), .FRAC_W(FRAC_W)) u_scale (
    .age_i     (pend_age),
    .elapsed_i (elapsed),
    .mult_i    (freq_mult_i),
    .age_o     (age_new)
  );

  age_thr_table #(.NUM_CORES(NUM_CORES), .IDX_W(CORE_W), .AGE_W(AGE_W)) u_thr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (thr_upd_valid_i),
    .wr_idx_i (thr_upd_core_i),
    .wr_val_i (thr_upd_value_i),
    .rd_idx_i (pend_core),
    .rd_val_o (thr_cur)
  );

  assign late = age_new > thr_cur;

  always_comb begin
    hdr_d                        = rsp_hdr_i;
    hdr_d[AGE_LSB +: AGE_W]      = age_new;
    hdr_d[CORE_LSB +: CORE_W]    = pend_core;
    hdr_d[PRIO_BIT]              = late;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      hdr_q <= '0;
    end else begin
      vld_q <= rsp_valid_i;
      if (rsp_valid_i) hdr_q <= hdr_d;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_hdr_o   = hdr_q;
endmodule

module age_lateness_chk import age_pkg::*; #(
  parameter int MULT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MULT_W-1:0] freq_mult_i,
  input logic              thr_upd_valid_i,
  input logic              rsp_valid_i,
  input logic [HDR_W-1:0]  rsp_hdr_i,
  input logic              rsp_valid_o,
  input logic [HDR_W-1:0]  rsp_hdr_o,
  input logic              pend_vld,
  input logic [CORE_W-1:0] pend_core,
  input logic [AGE_W-1:0]  pend_age
);
  logic upd_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              upd_seen_q <= 1'b0;
    else if (thr_upd_valid_i) upd_seen_q <= 1'b1;
  end

  assert_rsp_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> rsp_valid_o);
  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_i |=> !rsp_valid_o);
  assert_tag_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> pend_vld);
  assert_age_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> rsp_hdr_o[AGE_LSB +: AGE_W] >= $past(pend_age));
  assert_zero_mult_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && freq_mult_i == '0) |=> rsp_hdr_o[AGE_LSB +: AGE_W] == $past(pend_age));
  assert_late_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hdr_o[PRIO_BIT]) |-> rsp_hdr_o[AGE_LSB +: AGE_W] != '0);
  assert_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> (rsp_hdr_o[HDR_W-1:PRIO_BIT+1] == $past(rsp_hdr_i[HDR_W-1:PRIO_BIT+1]))
                   && (rsp_hdr_o[CORE_LSB +: CORE_W] == $past(pend_core)));
  assert_never_late_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_seen_q && rsp_valid_o) |-> !rsp_hdr_o[PRIO_BIT]);
endmodule

bind age_lateness_unit age_lateness_chk #(.MULT_W(MULT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .freq_mult_i     (freq_mult_i),
  .thr_upd_valid_i (thr_upd_valid_i),
  .rsp_valid_i     (rsp_valid_i),
  .rsp_hdr_i       (rsp_hdr_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_hdr_o       (rsp_hdr_o),
  .pend_vld        (pend_vld),
  .pend_core       (pend_core),
  .pend_age        (pend_age)
);

// File: tb/age_lateness_unit_tb_top.sv
`timescale 1ns/1ps
module age_lateness_unit_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   freq_mult_i = 8'd16;
  logic         thr_upd_valid_i = 1'b0;
  logic [4:0]   thr_upd_core_i = '0;
  logic [11:0]  thr_upd_value_i = '0;
  logic         req_valid_i = 1'b0;
  logic [2:0]   req_tag_i = '0;
  logic [4:0]   req_core_i = '0;
  logic [11:0]  req_age_i = '0;
  logic         rsp_valid_i = 1'b0;
  logic [2:0]   rsp_tag_i = '0;
  logic [127:0] rsp_hdr_i = '0;
  logic         rsp_valid_o;
  logic [127:0] rsp_hdr_o;

  always #2.5 clk_i = ~clk_i;

  age_lateness_unit dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  int m_thr [32];
  int m_age [8];
  int m_core [8];
  longint m_stamp [8];
  longint cyc = 0;
  bit exp_vld = 0;
  int exp_age = 0, exp_core = 0;
  bit exp_late = 0;
  logic [109:0] exp_up = '0;

  initial for (int i = 0; i < 32; i++) m_thr[i] = 4095;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      exp_vld = rsp_valid_i;
      if (rsp_valid_i) begin
        automatic int t = int'(rsp_tag_i);
        automatic longint inc = ((cyc - m_stamp[t]) * longint'(freq_mult_i)) / 16;
        automatic longint a = longint'(m_age[t]) + inc;
        if (a > 4095) a = 4095;
        exp_age  = int'(a);
        exp_core = m_core[t];
        exp_late = exp_age > m_thr[m_core[t]];
        exp_up   = rsp_hdr_i[127:18];
      end
      if (thr_upd_valid_i) m_thr[thr_upd_core_i] = int'(thr_upd_value_i);
      if (req_valid_i) begin
        m_age[req_tag_i]   = int'(req_age_i);
        m_core[req_tag_i]  = int'(req_core_i);
        m_stamp[req_tag_i] = cyc;
      end
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(rsp_valid_o == exp_vld, "R1 valid", rsp_valid_o, exp_vld);
      if (exp_vld) begin
        chk(int'(rsp_hdr_o[11:0]) == exp_age, "R3/R4 age", rsp_hdr_o[11:0], exp_age);
        chk(rsp_hdr_o[17] == exp_late, "R6 priority", rsp_hdr_o[17], exp_late);
        chk(int'(rsp_hdr_o[16:12]) == exp_core, "R7 core", rsp_hdr_o[16:12], exp_core);
        chk(rsp_hdr_o[127:18] == exp_up, "R7 upper bits", rsp_hdr_o[127:18] != exp_up, 0);
      end
    end
  end

  // elapsed cycles = w + 1
  task automatic txn(input int tag, input int core, input int age, input int w,
                     input int e_age, input bit e_late, input string rq);
    @(negedge clk_i);
    req_valid_i = 1; req_tag_i = 3'(tag); req_core_i = 5'(core); req_age_i = 12'(age);
    @(negedge clk_i);
    req_valid_i = 0;
    repeat (w) @(negedge clk_i);
    rsp_valid_i = 1; rsp_tag_i = 3'(tag); rsp_hdr_i = {110'(age * 7 + tag), 18'h0};
    @(negedge clk_i);
    rsp_valid_i = 0;
    chk(int'(rsp_hdr_o[11:0]) == e_age, rq, rsp_hdr_o[11:0], e_age);
    chk(rsp_hdr_o[17] == e_late, rq, rsp_hdr_o[17], e_late);
  endtask

  task automatic upd(input int core, input int val);
    @(negedge clk_i);
    thr_upd_valid_i = 1; thr_upd_core_i = 5'(core); thr_upd_value_i = 12'(val);
    @(negedge clk_i);
    thr_upd_valid_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R8 reset valid", rsp_valid_o, 0);
    rst_ni = 1;

    // R8 + R4: default threshold, saturation
    txn(0, 3, 4000, 199, 4095, 0, "R4/R8 saturate, default never late");
    // R6: equal vs greater
    upd(5, 100);
    txn(1, 5, 90, 9, 100, 0, "R6 equal not late");
    txn(1, 5, 90, 10, 101, 1, "R6 greater is late");
    // R3: fractional scaling rounded down
    freq_mult_i = 8'h18;
    txn(2, 5, 0, 2, 4, 0, "R3 mult 1.5 floor");
    freq_mult_i = 8'h08;
    txn(2, 5, 0, 2, 1, 0, "R3 mult 0.5 floor");
    freq_mult_i = 8'h10;
    // R9: other core untouched
    txn(3, 6, 200, 9, 210, 0, "R9 core6 keeps default");
    txn(3, 5, 200, 9, 210, 1, "R9 core5 uses its own");
    // R2: two outstanding slots, out-of-order completion
    @(negedge clk_i);
    req_valid_i = 1; req_tag_i = 3'd4; req_core_i = 5'd5; req_age_i = 12'd50;
    @(negedge clk_i);
    req_tag_i = 3'd5; req_core_i = 5'd6; req_age_i = 12'd500;
    @(negedge clk_i);
    req_valid_i = 0;
    rsp_valid_i = 1; rsp_tag_i = 3'd5; rsp_hdr_i = '0;
    @(negedge clk_i);
    rsp_tag_i = 3'd4;
    chk(int'(rsp_hdr_o[11:0]) == 501 && rsp_hdr_o[16:12] == 5'd6, "R2 slot5 kept", rsp_hdr_o[11:0], 501);
    @(negedge clk_i);
    rsp_valid_i = 0;
    chk(int'(rsp_hdr_o[11:0]) == 53 && rsp_hdr_o[16:12] == 5'd5, "R2 slot4 kept", rsp_hdr_o[11:0], 53);
    // R5: same-cycle update uses old threshold
    @(negedge clk_i);
    req_valid_i = 1; req_tag_i = 3'd6; req_core_i = 5'd7; req_age_i = 12'd50;
    @(negedge clk_i);
    req_tag_i = 3'd7;
    @(negedge clk_i);
    req_valid_i = 0;
    rsp_valid_i = 1; rsp_tag_i = 3'd6;
    thr_upd_valid_i = 1; thr_upd_core_i = 5'd7; thr_upd_value_i = 12'd10;
    @(negedge clk_i);
    thr_upd_valid_i = 0; rsp_tag_i = 3'd7;
    chk(rsp_hdr_o[17] == 1'b0, "R5 same-cycle uses old", rsp_hdr_o[17], 0);
    @(negedge clk_i);
    rsp_valid_i = 0;
    chk(rsp_hdr_o[17] == 1'b1, "R5 later uses new", rsp_hdr_o[17], 1);
    // R1: update alone gives no output
    upd(9, 5);
    chk(rsp_valid_o == 1'b0, "R1 no output on update", rsp_valid_o, 0);

    // mixed traffic, model compares every cycle
    begin
      bit pend [8];
      for (int i = 0; i < 8; i++) pend[i] = 0;
      for (int n = 0; n < 3000; n++) begin
        automatic int rt, qt;
        @(negedge clk_i);
        req_valid_i = 0; rsp_valid_i = 0; thr_upd_valid_i = 0;
        rt = -1;
        if ($urandom_range(0, 2) == 0) begin
          qt = $urandom_range(0, 7);
          if (pend[qt]) begin
            rsp_valid_i = 1; rsp_tag_i = 3'(qt);
            rsp_hdr_i = {$urandom, $urandom, $urandom, $urandom};
            pend[qt] = 0; rt = qt;
          end
        end
        if ($urandom_range(0, 2) == 0) begin
          qt = $urandom_range(0, 7);
          if (!pend[qt] && qt != rt) begin
            req_valid_i = 1; req_tag_i = 3'(qt);
            req_core_i = 5'($urandom_range(0, 31));
            req_age_i = 12'($urandom_range(0, 4095));
            pend[qt] = 1;
          end
        end
        if ($urandom_range(0, 9) == 0) begin
          thr_upd_valid_i = 1; thr_upd_core_i = 5'($urandom_range(0, 31));
          thr_upd_value_i = 12'($urandom_range(0, 4095));
        end
        if ($urandom_range(0, 49) == 0) freq_mult_i = 8'($urandom_range(0, 255));
      end
      @(negedge clk_i);
      req_valid_i = 0; rsp_valid_i = 0; thr_upd_valid_i = 0;
      repeat (2) @(negedge clk_i);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule